// File: doc/BRIEF.md
# Sorted Self-Routing Cell Switch

This block moves one batch of up to eight fixed cells from eight input slots to eight output slots on every clock. Each input slot carries a valid bit, a three-bit destination port number and a payload word. A batch that arrives at a rising edge appears at the outputs right after the next rising edge. The outputs are a valid bit and a payload per output port, plus one flag per input that marks a cell dropped because another cell had already claimed its destination.

Internally the batch passes through four combinational sections in a fixed order. A bitonic compare-exchange network sorts the cells by destination and puts empty slots last. A trap section removes repeat destinations. A concentrator closes the gaps so that the surviving cells sit in adjacent slots from slot 0 upward. A three-stage shuffle-exchange network of twelve 2x2 elements then steers each cell one destination bit per stage, starting with the most significant bit. A sorted, gap-free input is the condition under which this cheap network never has two cells competing for one element output. A single register bank after the network holds the result.

Top module: `sort_route_fabric`

## Requirements
- R1: While `rst_n` is low, and right after it goes low (the reset is asynchronous), `out_vld`, `out_data` and `trap_flag` are all zero.
- R2: A batch applied to the inputs before a rising edge shows at the outputs after that edge. The outputs do not change between edges, and a new batch is accepted on every edge.
- R3: A valid cell on input i with destination T (binary value of `in_tag[i]`, for example 3'b100) that is not trapped appears on output T with `out_vld[T]`=1 and `out_data[T]` equal to its payload. When all eight inputs are valid with distinct destinations, all eight cells are delivered.
- R4: When several valid inputs share a destination, only the one with the lowest input index is delivered. Each of the others sets `trap_flag` at its own input index and is not delivered.
- R5: An input with `in_vld[i]`=0 is ignored: it reaches no output and never sets `trap_flag[i]`. Every output with `out_vld`=0 carries `out_data`=0.
- R6: Each output carries at most one cell. The number of delivered cells plus the number of trapped cells equals the number of valid inputs in the batch.
- R7: For every batch, no two cells compete for the same slot in the concentrator or for the same element output in the routing network.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 8 | Per-input cell present |
| in_tag | input | 8x3 | Per-input destination port number |
| in_data | input | 8x16 | Per-input payload |
| out_vld | output | 8 | Per-output cell delivered |
| out_data | output | 8x16 | Per-output payload, zero when idle |
| trap_flag | output | 8 | Per-input cell dropped as a repeat destination |

## Verification
The block holds no state beyond the output register, so a fault in any section shows up one edge after the batch that triggers it. A sort or trap error shows as the wrong duplicate delivered or a wrong trap bit. A concentrator or routing error shows as a payload on the wrong port, a lost cell, or a delivered-plus-trapped count that differs from the valid count. Sweeping many random masks and destinations on consecutive cycles makes such a fault visible within the first few batches that exercise it.

// File: rtl/srf_pkg.sv
package srf_pkg;
    localparam int PORTS  = 8;
    localparam int TAG_W  = $clog2(PORTS);
    localparam int DATA_W = 16;
    localparam int KEY_W  = 1 + 2 * TAG_W;
    localparam int CNT_W  = TAG_W + 1;

    typedef struct packed {
        logic              vld;
        logic [TAG_W-1:0]  tag;
        logic [TAG_W-1:0]  src;
        logic [DATA_W-1:0] data;
    } cell_t;

    typedef struct packed {
        logic [PORTS-1:0]             vld;
        logic [PORTS-1:0][DATA_W-1:0] data;
        logic [PORTS-1:0]             trap;
    } port_state_t;

    // empty slots rank above every real destination; equal destinations
    // are ordered by input index so the lowest index comes first
    function automatic logic [KEY_W-1:0] sort_key(cell_t c);
        return {~c.vld, c.tag, c.src};
    endfunction

    // perfect shuffle: rotate the slot index left by one bit
    function automatic int shuffle_pos(int i);
        return ((i << 1) | (i >> (TAG_W - 1))) & (PORTS - 1);
    endfunction
endpackage

// File: rtl/srf_cmp_ex.sv
module srf_cmp_ex
    import srf_pkg::*;
#(
    parameter bit ASCEND = 1'b1
) (
    input  cell_t a_i,
    input  cell_t b_i,
    output cell_t lo_o,
    output cell_t hi_o
);
    logic swap;

    always_comb begin
        if (ASCEND) swap = sort_key(a_i) > sort_key(b_i);
        else        swap = sort_key(a_i) < sort_key(b_i);
        lo_o = swap ? b_i : a_i;
        hi_o = swap ? a_i : b_i;
    end
endmodule

// File: rtl/srf_bitonic_sorter.sv
module srf_bitonic_sorter
    import srf_pkg::*;
(
    input  cell_t cells_i [PORTS],
    output cell_t cells_o [PORTS]
);
    localparam int NSTG = TAG_W * (TAG_W + 1) / 2;

    cell_t lvl [NSTG+1][PORTS];

    for (genvar i = 0; i < PORTS; i++) begin : g_io
        assign lvl[0][i]  = cells_i[i];
        assign cells_o[i] = lvl[NSTG][i];
    end

    // phase p merges blocks of 2**p; step q compares slots 2**q apart
    for (genvar p = 1; p <= TAG_W; p++) begin : g_phase
        for (genvar q = p - 1; q >= 0; q--) begin : g_step
            localparam int S = p * (p - 1) / 2 + (p - 1 - q);
            for (genvar i = 0; i < PORTS; i++) begin : g_node
                localparam int L = i ^ (1 << q);
                if (L > i) begin : g_cmp
                    localparam bit ASC = ((i >> p) & 1) == 0;
                    srf_cmp_ex #(.ASCEND(ASC)) u_cmp (
                        .a_i  (lvl[S][i]),
                        .b_i  (lvl[S][L]),
                        .lo_o (lvl[S+1][i]),
                        .hi_o (lvl[S+1][L])
                    );
                end
            end
        end
    end
endmodule

// File: rtl/srf_trap.sv
module srf_trap
    import srf_pkg::*;
(
    input  cell_t            sorted_i [PORTS],
    output cell_t            kept_o   [PORTS],
    output logic [PORTS-1:0] trapped_o
);
    always_comb begin
        trapped_o = '0;
        kept_o[0] = sorted_i[0];
        for (int i = 1; i < PORTS; i++) begin
            kept_o[i] = sorted_i[i];
            if (sorted_i[i].vld && sorted_i[i-1].vld &&
                sorted_i[i].tag == sorted_i[i-1].tag) begin
                kept_o[i].vld = 1'b0;
                trapped_o[sorted_i[i].src] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/srf_concentrator.sv
module srf_concentrator
    import srf_pkg::*;
(
    input  cell_t cells_i [PORTS],
    output cell_t cells_o [PORTS],
    output logic  collide_o
);
    logic [CNT_W-1:0] rank [PORTS];
    logic [CNT_W-1:0] run;
    logic [CNT_W-1:0] hits;

    always_comb begin
        run = '0;
        for (int i = 0; i < PORTS; i++) begin
            rank[i] = run;
            run     = run + CNT_W'(cells_i[i].vld);
        end
        collide_o = 1'b0;
        for (int o = 0; o < PORTS; o++) begin
            cells_o[o] = '0;
            hits       = '0;
            for (int i = 0; i < PORTS; i++) begin
                if (cells_i[i].vld && rank[i] == CNT_W'(o)) begin
                    cells_o[o] = cells_i[i];
                    hits       = hits + 1'b1;
                end
            end
            if (hits > CNT_W'(1)) collide_o = 1'b1;
        end
    end
endmodule

// File: rtl/srf_switch2.sv
module srf_switch2
    import srf_pkg::*;
#(
    parameter int BIT = 0
) (
    input  cell_t a_i,
    input  cell_t b_i,
    output cell_t up_o,
    output cell_t dn_o,
    output logic  collide_o
);
    always_comb begin
        up_o      = '0;
        dn_o      = '0;
        collide_o = a_i.vld && b_i.vld && (a_i.tag[BIT] == b_i.tag[BIT]);
        if (b_i.vld) begin
            if (b_i.tag[BIT]) dn_o = b_i;
            else              up_o = b_i;
        end
        if (a_i.vld) begin
            if (a_i.tag[BIT]) dn_o = a_i;
            else              up_o = a_i;
        end
    end
endmodule

// File: rtl/srf_omega.sv
module srf_omega
    import srf_pkg::*;
(
    input  cell_t cells_i [PORTS],
    output cell_t cells_o [PORTS],
    output logic  collide_o
);
    localparam int HALF = PORTS / 2;

    cell_t stg [TAG_W+1][PORTS];
    cell_t shf [TAG_W][PORTS];
    logic [TAG_W*HALF-1:0] col;

    for (genvar i = 0; i < PORTS; i++) begin : g_io
        assign stg[0][i]  = cells_i[i];
        assign cells_o[i] = stg[TAG_W][i];
    end

    for (genvar s = 0; s < TAG_W; s++) begin : g_stage
        for (genvar i = 0; i < PORTS; i++) begin : g_wire
            localparam int D = shuffle_pos(i);
            assign shf[s][D] = stg[s][i];
        end
        for (genvar m = 0; m < HALF; m++) begin : g_elem
            srf_switch2 #(.BIT(TAG_W - 1 - s)) u_sw (
                .a_i       (shf[s][2*m]),
                .b_i       (shf[s][2*m+1]),
                .up_o      (stg[s+1][2*m]),
                .dn_o      (stg[s+1][2*m+1]),
                .collide_o (col[s*HALF+m])
            );
        end
    end

    assign collide_o = |col;
endmodule

// File: rtl/sort_route_fabric.sv
module sort_route_fabric
    import srf_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [PORTS-1:0]             in_vld,
    input  logic [PORTS-1:0][TAG_W-1:0]  in_tag,
    input  logic [PORTS-1:0][DATA_W-1:0] in_data,
    output logic [PORTS-1:0]             out_vld,
    output logic [PORTS-1:0][DATA_W-1:0] out_data,
    output logic [PORTS-1:0]             trap_flag
);
    cell_t            cell_in  [PORTS];
    cell_t            sorted   [PORTS];
    cell_t            kept     [PORTS];
    cell_t            compact  [PORTS];
    cell_t            routed   [PORTS];
    logic [PORTS-1:0] trapped;
    logic             conc_collide;
    logic             omega_collide;
    logic             fab_collide;

    always_comb begin
        for (int i = 0; i < PORTS; i++) begin
            cell_in[i].vld  = in_vld[i];
            cell_in[i].tag  = in_vld[i] ? in_tag[i] : '0;
            cell_in[i].src  = TAG_W'(i);
            cell_in[i].data = in_data[i];
        end
    end

    srf_bitonic_sorter u_sort (
        .cells_i (cell_in),
        .cells_o (sorted)
    );

    srf_trap u_trap (
        .sorted_i  (sorted),
        .kept_o    (kept),
        .trapped_o (trapped)
    );

    srf_concentrator u_conc (
        .cells_i   (kept),
        .cells_o   (compact),
        .collide_o (conc_collide)
    );

    srf_omega u_route (
        .cells_i   (compact),
        .cells_o   (routed),
        .collide_o (omega_collide)
    );

    assign fab_collide = conc_collide | omega_collide;

    port_state_t st_d, st_q;

    always_comb begin
        st_d = '0;
        for (int o = 0; o < PORTS; o++) begin
            if (routed[o].vld && routed[o].tag == TAG_W'(o)) begin
                st_d.vld[o]  = 1'b1;
                st_d.data[o] = routed[o].data;
            end
        end
        st_d.trap = trapped;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld   = st_q.vld;
    assign out_data  = st_q.data;
    assign trap_flag = st_q.trap;
endmodule

// File: rtl/srf_chk.sv
module srf_chk
    import srf_pkg::*;
(
    input logic                         clk,
    input logic                         rst_n,
    input logic [PORTS-1:0]             in_vld,
    input logic [PORTS-1:0]             out_vld,
    input logic [PORTS-1:0][DATA_W-1:0] out_data,
    input logic [PORTS-1:0]             trap_flag,
    input logic                         collide
);
    // R7
    no_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !collide);

    // R5
    trap_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (trap_flag & ~$past(in_vld)) == '0);

    // R6
    cell_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($countones(out_vld) + $countones(trap_flag)
                          == $countones($past(in_vld))));

    for (genvar o = 0; o < PORTS; o++) begin : g_idle
        // R5
        idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !out_vld[o] |-> out_data[o] == '0);
    end
endmodule

bind sort_route_fabric srf_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_vld    (in_vld),
    .out_vld   (out_vld),
    .out_data  (out_data),
    .trap_flag (trap_flag),
    .collide   (fab_collide)
);

// File: tb/sort_route_fabric_tb_top.sv
module sort_route_fabric_tb_top;
    import srf_pkg::*;

    localparam int VW = PORTS + PORTS * TAG_W;
    localparam int NV = 10;
    // {valid mask, destinations}; octal digit k from the left is input 7-k
    localparam logic [VW-1:0] VECS [NV] = '{
        {8'hFF, 24'o76543210},   // R3 identity
        {8'hFF, 24'o01234567},   // R3 reversed
        {8'h01, 24'o00000004},   // R3 tag 100 to port 4
        {8'hFF, 24'o33333333},   // R4 all same
        {8'hA5, 24'o12345670},
        {8'h00, 24'o77777777},   // R5 nothing valid
        {8'h5A, 24'o31313131},   // R4 two groups
        {8'h81, 24'o70000007},   // R4 far duplicate
        {8'hF0, 24'o02460000},
        {8'h3C, 24'o55522255}
    };

    logic                         clk = 1'b0;
    logic                         rst_n;
    logic [PORTS-1:0]             in_vld;
    logic [PORTS-1:0][TAG_W-1:0]  in_tag;
    logic [PORTS-1:0][DATA_W-1:0] in_data;
    logic [PORTS-1:0]             out_vld;
    logic [PORTS-1:0][DATA_W-1:0] out_data;
    logic [PORTS-1:0]             trap_flag;

    logic [PORTS-1:0]             exp_vld, prv_vld;
    logic [PORTS-1:0][DATA_W-1:0] exp_data, prv_data;
    logic [PORTS-1:0]             exp_trap, prv_trap;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    sort_route_fabric dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_vld    (in_vld),
        .in_tag    (in_tag),
        .in_data   (in_data),
        .out_vld   (out_vld),
        .out_data  (out_data),
        .trap_flag (trap_flag)
    );

    task automatic clear_exp();
        exp_vld  = '0;
        exp_data = '0;
        exp_trap = '0;
    endtask

    task automatic drive(input logic [PORTS-1:0] v,
                         input logic [PORTS-1:0][TAG_W-1:0] t, input int seed);
        in_vld = v;
        in_tag = t;
        for (int i = 0; i < PORTS; i++) in_data[i] = DATA_W'(seed * 131 + i * 17 + 1);
        clear_exp();
        for (int d = 0; d < PORTS; d++) begin
            bit taken = 1'b0;
            for (int i = 0; i < PORTS; i++) begin
                if (v[i] && int'(t[i]) == d) begin
                    if (!taken) begin
                        exp_vld[d]  = 1'b1;
                        exp_data[d] = in_data[i];
                        taken       = 1'b1;
                    end else begin
                        exp_trap[i] = 1'b1;
                    end
                end
            end
        end
    endtask

    task automatic check_out(input string req);
        n_chk++;
        if (out_vld !== exp_vld) begin
            n_bad++;
            $display("FAIL %s out_vld actual %b expected %b", req, out_vld, exp_vld);
        end
        n_chk++;
        if (out_data !== exp_data) begin
            n_bad++;
            $display("FAIL %s out_data actual %h expected %h", req, out_data, exp_data);
        end
        n_chk++;
        if (trap_flag !== exp_trap) begin
            n_bad++;
            $display("FAIL %s trap_flag actual %b expected %b", req, trap_flag, exp_trap);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual running expected finished");
        finish_run();
    end

    initial begin
        rst_n   = 1'b0;
        in_vld  = '0;
        in_tag  = '0;
        in_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        clear_exp();
        check_out("R1 after reset");

        // table walk, one batch per cycle
        for (int n = 0; n < NV; n++) begin
            drive(VECS[n][VW-1:PORTS*TAG_W], VECS[n][PORTS*TAG_W-1:0], n);
            @(negedge clk);
            check_out("R3/R4/R5/R6 table");
        end

        // R2: outputs hold until the edge, then take the new batch
        drive(VECS[0][VW-1:PORTS*TAG_W], VECS[0][PORTS*TAG_W-1:0], 50);
        @(negedge clk);
        check_out("R2 first batch");
        prv_vld  = exp_vld;
        prv_data = exp_data;
        prv_trap = exp_trap;
        drive('1, {PORTS{3'd5}}, 51);
        #1;
        n_chk++;
        if (out_vld !== prv_vld || out_data !== prv_data || trap_flag !== prv_trap) begin
            n_bad++;
            $display("FAIL R2 held outputs actual %b/%b expected %b/%b",
                     out_vld, trap_flag, prv_vld, prv_trap);
        end
        @(negedge clk);
        check_out("R2/R4 next batch");

        // R5: empty mask with busy destinations
        drive('0, 24'o12345670, 60);
        @(negedge clk);
        check_out("R5 empty mask");

        // random sweep on consecutive cycles
        for (int n = 0; n < 400; n++) begin
            logic [PORTS-1:0]            rv;
            logic [PORTS-1:0][TAG_W-1:0] rt;
            rv = PORTS'($urandom);
            rt = (PORTS*TAG_W)'($urandom);
            if (n % 7 == 0) rv = '1;
            drive(rv, rt, 100 + n);
            @(negedge clk);
            check_out("R3/R4/R5/R6/R7 random");
        end

        // R1: reset in the middle of traffic
        drive('1, 24'o76543210, 900);
        @(negedge clk);
        check_out("R3 before reset");
        rst_n = 1'b0;
        #1;
        clear_exp();
        check_out("R1 async clear");
        @(negedge clk);
        check_out("R1 held in reset");
        rst_n = 1'b1;
        drive(8'hC3, 24'o44000044, 901);
        @(negedge clk);
        check_out("R4 after reset");

        finish_run();
    end
endmodule